// File: doc/BRIEF.md
# Signed Multi-Channel Motor PWM Bank

This block turns a set of signed motor commands into one pulse-width output and one direction output per channel. All channels share a free-running period counter that advances by one on each clock where the prescale enable is high. Each command is split into a magnitude and a sign. The magnitude becomes the compare value for that channel's pulse. The sign gives a direction bit, which a per-channel reverse mask can invert to suit how the motor is wired.

Commands are written into shadow registers when a valid strobe is seen. The shadow registers move into the active registers only at the counter wrap. Because of this, the duty and the direction of every channel change in the same clock, on the first count of a new period. A partial pulse or a motor briefly driven the wrong way is never seen. A command whose magnitude is larger than the maximum duty is clamped to that maximum, and it raises a sticky error flag.

Top module: `motor_pwm_bank`

## Requirements
- R1: While `rst_ni` is low and right after it rises, every `pwm_o` bit is 0, `dir_o` equals `rev_mask_i`, and `err_o` is 0.
- R2: The period counter advances by one only on clocks where `tick_en_i` is high. It wraps from 2**CNT_W-1 to 0, so one period is 2**CNT_W ticks. While `tick_en_i` is low, no output changes.
- R3: A channel's `pwm_o` is high while the counter is below its active compare value and low otherwise. A compare value of 0 keeps the output low, and the number of high ticks in one period equals the compare value.
- R4: A positive command gives compare value = command and direction bit 1. A negative command gives compare value = |command| and direction bit 0. A command of zero gives compare value 0 and direction bit 0.
- R5: `dir_o[c]` is the active direction bit of channel c XOR `rev_mask_i[c]`. Bit c of the mask belongs to channel c, and a change of the mask acts on `dir_o` at once.
- R6: Commands are captured on a clock where `cmd_valid_i` is high. They reach the outputs only at the next counter wrap, so they do not change the outputs before it.
- R7: At a wrap, the duty and the direction of every channel update in the same clock. That clock is the one where the counter shows 0.
- R8: A command with |command| > MAX_DUTY is clamped to compare value MAX_DUTY, and its sign is kept. When such a command is captured, `err_o` is set. A command with |command| = MAX_DUTY does not set `err_o`. The most negative code is out of range.
- R9: `err_o` stays set until a clock with `err_clr_i` high. If a new out-of-range capture falls on the same clock as the clear, `err_o` stays set.
- R10: `cmd_i` holds channel c's two's-complement command in bits [c*CMD_W +: CMD_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Prescale enable; the counter advances when high |
| cmd_i | input | NUM_CH*CMD_W | Packed signed commands, channel 0 in the low bits |
| cmd_valid_i | input | 1 | Captures `cmd_i` into the shadow registers |
| rev_mask_i | input | NUM_CH | Per-channel direction inversion |
| err_clr_i | input | 1 | Clears the sticky error flag |
| pwm_o | output | NUM_CH | Pulse outputs, high-active |
| dir_o | output | NUM_CH | Direction outputs |
| err_o | output | 1 | Sticky out-of-range flag |

## Verification
The bench builds the block with four channels, CNT_W=6 (a 64-tick period), CMD_W=8 and MAX_DUTY=50. With the short period, many period boundaries fit in a short run, so high-time counts over a full period can be checked exactly. The 8-bit command width puts both clamp paths within reach with values the bench can write by hand: one step past the limit in either sign, and the most negative code -128. All four channels flip direction in one update, so a skew between channels at the boundary would be seen. A half-rate enable pattern checks that the pulse widths scale with the tick rate.

// File: rtl/motor_pwm_pkg.sv
package motor_pwm_pkg;
  typedef enum logic [1:0] {
    SGN_ZERO = 2'd0,
    SGN_NEG  = 2'd1,
    SGN_POS  = 2'd2
  } sgn_e;
endpackage

// File: rtl/mpb_period_counter.sv
module mpb_period_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == TOP);
endmodule

// File: rtl/mpb_cmd_decode.sv
module mpb_cmd_decode
  import motor_pwm_pkg::*;
#(
  parameter int CMD_W    = 12,
  parameter int CNT_W    = 10,
  parameter int MAX_DUTY = 1000
) (
  input  logic [CMD_W-1:0] cmd_i,
  output logic [CNT_W-1:0] duty_o,
  output logic             dir_o,
  output logic             ovf_o
);
  localparam int WW = CMD_W + CNT_W;
  localparam logic [WW-1:0] MAX_W = WW'(MAX_DUTY);

  sgn_e             sgn;
  logic [CMD_W-1:0] mag;
  logic [WW-1:0]    mag_w;

  always_comb begin
    if (cmd_i == '0)          sgn = SGN_ZERO;
    else if (cmd_i[CMD_W-1])  sgn = SGN_NEG;
    else                      sgn = SGN_POS;
  end

  // two's complement magnitude; most negative code stays unsigned-correct
  assign mag    = (sgn == SGN_NEG) ? (~cmd_i + CMD_W'(1)) : cmd_i;
  assign mag_w  = WW'(mag);
  assign ovf_o  = mag_w > MAX_W;
  assign duty_o = ovf_o ? MAX_W[CNT_W-1:0] : mag_w[CNT_W-1:0];
  assign dir_o  = (sgn == SGN_POS);
endmodule

// File: rtl/mpb_channel.sv
module mpb_channel #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             dir_i,
  input  logic             rev_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pwm_o,
  output logic             dir_o
);
  logic [CNT_W-1:0] shd_duty_q, act_duty_q;
  logic             shd_dir_q,  act_dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_duty_q <= '0;
      shd_dir_q  <= 1'b0;
    end else if (load_i) begin
      shd_duty_q <= duty_i;
      shd_dir_q  <= dir_i;
    end
  end

  // duty and direction move together, only at wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_duty_q <= '0;
      act_dir_q  <= 1'b0;
    end else if (wrap_i) begin
      act_duty_q <= shd_duty_q;
      act_dir_q  <= shd_dir_q;
    end
  end

  assign pwm_o = cnt_i < act_duty_q;
  assign dir_o = act_dir_q ^ rev_i;
endmodule

// File: rtl/motor_pwm_bank.sv
module motor_pwm_bank
  import motor_pwm_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CMD_W    = 12,
  parameter int CNT_W    = 10,
  parameter int MAX_DUTY = 1000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_en_i,
  input  logic [NUM_CH*CMD_W-1:0] cmd_i,
  input  logic                    cmd_valid_i,
  input  logic [NUM_CH-1:0]       rev_mask_i,
  input  logic                    err_clr_i,
  output logic [NUM_CH-1:0]       pwm_o,
  output logic [NUM_CH-1:0]       dir_o,
  output logic                    err_o
);
  localparam int TOP_I   = (1 << CNT_W) - 1;
  localparam int MAX_EFF = (MAX_DUTY > TOP_I) ? TOP_I : MAX_DUTY;

  logic [CNT_W-1:0]  cnt_w;
  logic              wrap_w;
  logic [NUM_CH-1:0] ovf_w;
  logic              err_q;

  mpb_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_en_i),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] duty_w;
    logic             dir_w;

    mpb_cmd_decode #(
      .CMD_W    (CMD_W),
      .CNT_W    (CNT_W),
      .MAX_DUTY (MAX_EFF)
    ) u_dec (
      .cmd_i  (cmd_i[c*CMD_W +: CMD_W]),
      .duty_o (duty_w),
      .dir_o  (dir_w),
      .ovf_o  (ovf_w[c])
    );

    mpb_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (cmd_valid_i),
      .wrap_i (wrap_w),
      .duty_i (duty_w),
      .dir_i  (dir_w),
      .rev_i  (rev_mask_i[c]),
      .cnt_i  (cnt_w),
      .pwm_o  (pwm_o[c]),
      .dir_o  (dir_o[c])
    );
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      err_q <= 1'b0;
    else if (cmd_valid_i && |ovf_w)   err_q <= 1'b1;
    else if (err_clr_i)               err_q <= 1'b0;
  end

  assign err_o = err_q;
endmodule

// File: rtl/motor_pwm_bank_sva.sv
module motor_pwm_bank_sva #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_en_i,
  input logic              cmd_valid_i,
  input logic              err_clr_i,
  input logic [NUM_CH-1:0] rev_mask_i,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] dir_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  cnt_i
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |=> $stable(cnt_i));

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i |=> cnt_i == CNT_W'($past(cnt_i) + CNT_W'(1)));

  assert_dir_at_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rev_mask_i) && !$stable(dir_o)) |-> (cnt_i == '0 && $past(tick_en_i)));

  assert_pwm_low_at_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == TOP) |-> (pwm_o == '0));

  assert_err_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(cmd_valid_i));

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
endmodule

bind motor_pwm_bank motor_pwm_bank_sva #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_en_i   (tick_en_i),
  .cmd_valid_i (cmd_valid_i),
  .err_clr_i   (err_clr_i),
  .rev_mask_i  (rev_mask_i),
  .pwm_o       (pwm_o),
  .dir_o       (dir_o),
  .err_o       (err_o),
  .cnt_i       (cnt_w)
);

// File: tb/motor_pwm_bank_tb.sv
module motor_pwm_bank_tb;
  localparam int NCH  = 4;
  localparam int CW   = 8;
  localparam int NW   = 6;
  localparam int MAXD = 50;
  localparam int P    = 1 << NW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_en = 1'b1;
  logic [NCH*CW-1:0] cmd = '0;
  logic             cmd_valid = 1'b0;
  logic [NCH-1:0]   rev = '0;
  logic             err_clr = 1'b0;
  logic [NCH-1:0]   pwm, dir;
  logic             err;

  int checks = 0;
  int fails  = 0;
  int hi[NCH];
  bit done = 1'b0;

  always #4 clk = ~clk;

  motor_pwm_bank #(
    .NUM_CH(NCH), .CMD_W(CW), .CNT_W(NW), .MAX_DUTY(MAXD)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .cmd_i(cmd),
    .cmd_valid_i(cmd_valid), .rev_mask_i(rev), .err_clr_i(err_clr),
    .pwm_o(pwm), .dir_o(dir), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int c0, input int c1, input int c2, input int c3, input bit clr = 1'b0);
    @(negedge clk);
    cmd       = {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
    cmd_valid = 1'b1;
    err_clr   = clr;
    @(negedge clk);
    cmd_valid = 1'b0;
    err_clr   = 1'b0;
  endtask

  task automatic settle();
    repeat (2*P) @(negedge clk);
  endtask

  task automatic measure(input int n, input bit toggle);
    for (int c = 0; c < NCH; c++) hi[c] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) hi[c] += int'(pwm[c]);
      if (toggle) tick_en = ~tick_en;
    end
  endtask

  task automatic chk_duty(input int e[NCH], input int mult, input string req);
    for (int c = 0; c < NCH; c++)
      chk(hi[c] == e[c]*mult, req, hi[c], e[c]*mult);
  endtask

  task automatic t_reset();
    rev = 4'b0101;
    repeat (3) @(negedge clk);
    chk(pwm == '0, "R1 pwm in reset", int'(pwm), 0);
    chk(dir == 4'b0101, "R1 dir in reset", int'(dir), 5);
    chk(err == 1'b0, "R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm == '0, "R1 pwm after reset", int'(pwm), 0);
    chk(dir == 4'b0101, "R1 dir after reset", int'(dir), 5);
    rev = '0;
  endtask

  task automatic t_decode();
    apply(20, -30, 0, 50);
    settle();
    measure(P, 1'b0);
    chk_duty('{20, 30, 0, 50}, 1, "R3 R4 R10 duty");
    chk(dir == 4'b1001, "R4 dir bits", int'(dir), 9);
    chk(err == 1'b0, "R8 exact max no error", int'(err), 0);
  endtask

  task automatic t_reverse();
    rev = 4'b1010;
    @(negedge clk);
    chk(dir == 4'b0011, "R5 mask applied", int'(dir), 3);
    measure(P, 1'b0);
    chk(hi[0] == 20, "R5 duty unaffected", hi[0], 20);
    rev = '0;
    @(negedge clk);
    chk(dir == 4'b1001, "R5 mask removed", int'(dir), 9);
  endtask

  task automatic t_boundary();
    logic [NCH-1:0] prev_pwm;
    bit found = 1'b0;
    apply(-10, 40, 5, -7);
    prev_pwm = pwm;
    for (int k = 0; k < 2*P+4 && !found; k++) begin
      @(negedge clk);
      if (dir != 4'b1001) begin
        found = 1'b1;
        chk(dir == 4'b0110, "R7 all dirs same cycle", int'(dir), 6);
        chk(pwm == 4'b1111, "R7 duty starts with dir", int'(pwm), 15);
        chk(prev_pwm == '0, "R7 old period ended", int'(prev_pwm), 0);
      end
      prev_pwm = pwm;
    end
    chk(found, "R6 update reached outputs", int'(found), 1);
    settle();
    measure(P, 1'b0);
    chk_duty('{10, 40, 5, 7}, 1, "R3 second pattern");
  endtask

  task automatic t_hold();
    logic [NCH-1:0] p0, d0;
    int chg = 0;
    tick_en = 1'b0;
    @(negedge clk);
    p0 = pwm; d0 = dir;
    apply(30, -30, 30, -30);
    repeat (100) begin
      @(negedge clk);
      if (pwm != p0 || dir != d0) chg++;
    end
    chk(chg == 0, "R2 R6 frozen without tick", chg, 0);
    tick_en = 1'b1;
    settle();
    measure(P, 1'b0);
    chk_duty('{30, 30, 30, 30}, 1, "R6 applied after tick");
    chk(dir == 4'b0101, "R4 alternating signs", int'(dir), 5);
  endtask

  task automatic t_prescale();
    apply(12, -25, 0, 40);
    repeat (4*P) begin
      @(negedge clk);
      tick_en = ~tick_en;
    end
    measure(2*P, 1'b1);
    chk_duty('{12, 25, 0, 40}, 2, "R2 half rate widths");
    tick_en = 1'b1;
  endtask

  task automatic t_err();
    apply(60, 0, 0, 0);
    chk(err == 1'b1, "R8 overflow flags", int'(err), 1);
    settle();
    measure(P, 1'b0);
    chk(hi[0] == MAXD, "R8 positive clamp", hi[0], MAXD);
    chk(dir[0] == 1'b1, "R8 sign kept", int'(dir[0]), 1);
    apply(0, -128, 0, 0);
    settle();
    measure(P, 1'b0);
    chk(hi[1] == MAXD, "R8 most negative clamp", hi[1], MAXD);
    chk(dir[1] == 1'b0, "R8 negative sign kept", int'(dir[1]), 0);
    apply(0, 0, -51, 0);
    settle();
    measure(P, 1'b0);
    chk(hi[2] == MAXD, "R8 just past limit", hi[2], MAXD);
    apply(1, 2, 3, 4);
    chk(err == 1'b1, "R9 sticky", int'(err), 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(err == 1'b0, "R9 cleared", int'(err), 0);
    apply(0, 0, 0, -60, 1'b1);
    chk(err == 1'b1, "R9 set beats clear", int'(err), 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    apply(-50, 50, 0, 0);
    chk(err == 1'b0, "R8 limit both signs legal", int'(err), 0);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_reverse();
    t_boundary();
    t_hold();
    t_prescale();
    t_err();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule